// File: doc/BRIEF.md
# UART Receive Idle Timeout

This block sits beside a UART receiver and its receive FIFO. It decides when received data has been left in the FIFO too long. While the FIFO holds at least one character, it counts elapsed line time in whole character frames. When the programmed number of frames passes with no new character, it raises a sticky timeout flag. Software or a neighbouring controller can then drain the FIFO even though it is not full.

The length of one frame comes from the live character format: start bit, data bits, optional parity bit and the stop bits. Time is kept in half-bit units, so the one-and-a-half stop bit case stays exact across many frames. A bit-time strobe from the baud generator advances the count. A received-character pulse restarts it. An empty FIFO holds it at zero. A clear strobe drops the flag. The frame-count setting is 8 bits wide, and zero selects the longest interval.

Top module: `uart_rx_idle_timer`

## Requirements
- R1: Time accumulates only while `fifo_nonempty` is 1. In any cycle where it is 0, the elapsed count returns to zero and stays there, and bit ticks in those cycles are lost.
- R2: A cycle with `char_rx` = 1 restarts the elapsed count from zero. The `bit_tick` of that same cycle is discarded, and this restart wins over an expiry that the tick would have caused.
- R3: Elapsed time is 2 half-bits per accepted `bit_tick`. Let N be the frame setting and L the frame length in half-bits. `timeout_flag` becomes 1 in the cycle after the accepted tick that first brings the elapsed time to N*L or more, which is tick number ceil(N*L/2).
- R4: `frame_limit` values 1 to 255 give N equal to that value. Value 0 gives N = 256.
- R5: The frame length in half-bits is L = 2*(1 + D + P) + S. D = `size_code` + 5 (code 0 to 3 gives 5 to 8 data bits), and P = `parity_en`. S = 2 when `long_stop` is 0. When `long_stop` is 1, S = 3 for 5 data bits and S = 4 for any other size.
- R6: `timeout_flag` stays 1 until a cycle with `flag_clr` = 1, and it goes to 0 in the cycle after that strobe. While the flag is 1, ticks are not counted. Once it is cleared, a full new interval must pass before it is set again.
- R7: If an expiry and `flag_clr` fall in the same cycle, the flag is set.
- R8: After reset, `timeout_flag` is 0 and the elapsed count is zero. A FIFO that already holds data then needs a full interval to time out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_nonempty | input | 1 | Receive FIFO holds at least one entry |
| char_rx | input | 1 | One-cycle pulse per character written into the FIFO |
| size_code | input | 2 | Data bits per character, value + 5 |
| parity_en | input | 1 | Frame carries a parity bit |
| long_stop | input | 1 | Long stop mode (1.5 stop bits for 5-bit characters, 2 otherwise) |
| bit_tick | input | 1 | One-cycle strobe once per bit time |
| frame_limit | input | 8 | Frames of silence before timeout, 0 selects 256 |
| flag_clr | input | 1 | One-cycle strobe that clears the flag |
| timeout_flag | output | 1 | Sticky receive timeout flag |

## Verification
Two pairs of events can fall on the same clock edge. The first pair is the expiring bit tick together with a clear strobe, which must leave the flag set. The second pair is the expiring tick together with a received-character pulse, which must suppress the flag and restart the interval. The bench brings each pair about by counting ticks up to one short of the computed expiry. It then drives the final tick in the same cycle as the competing strobe. It judges the flag one cycle later, and for the restart case it also confirms that a complete fresh interval is needed afterwards.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
   localparam int unsigned HALF_W = 5;
   typedef logic [HALF_W-1:0] halves_t;
   localparam int unsigned MIN_FRAME_HALVES = 14;
   localparam int unsigned MAX_FRAME_HALVES = 24;

   typedef struct packed {
      logic [1:0] size_code;
      logic       parity_on;
      logic       long_stop;
   } char_fmt_t;
endpackage

// File: rtl/rxto_frame_len.sv
module rxto_frame_len
   import rxto_pkg::*;
#(
   parameter int unsigned MIN_DATA_BITS    = 5,
   parameter bit          HALF_STOP_ON_MIN = 1'b1
) (
   input  char_fmt_t fmt,
   output halves_t   len_halves
);
   localparam int unsigned MAX_BODY = 1 + MIN_DATA_BITS + 3 + 1;

   if (MIN_DATA_BITS < 1) begin : g_bad_bits
      $error("rxto_frame_len: MIN_DATA_BITS must be positive");
   end
   if (2 * MAX_BODY + 4 >= (1 << HALF_W)) begin : g_bad_width
      $error("rxto_frame_len: frame length does not fit in halves_t");
   end

   logic [HALF_W-1:0] body_bits;
   logic [2:0]        stop_halves;

   if (HALF_STOP_ON_MIN) begin : g_half_stop
      always_comb begin
         if (!fmt.long_stop)               stop_halves = 3'd2;
         else if (fmt.size_code == 2'd0)   stop_halves = 3'd3;
         else                              stop_halves = 3'd4;
      end
   end else begin : g_whole_stop
      always_comb stop_halves = fmt.long_stop ? 3'd4 : 3'd2;
   end

   always_comb begin
      body_bits  = HALF_W'(1 + MIN_DATA_BITS) + HALF_W'(fmt.size_code)
                 + HALF_W'(fmt.parity_on);
      len_halves = HALF_W'({body_bits, 1'b0}) + HALF_W'(stop_halves);
   end
endmodule

// File: rtl/rxto_half_accum.sv
module rxto_half_accum
   import rxto_pkg::*;
#(
   parameter int unsigned TICK_HALVES = 2
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    bit_tick,
   input  logic    restart,
   input  logic    hold,
   input  logic    expire,
   input  halves_t len_halves,
   output logic    frame_step
);
   localparam int unsigned SUM_W = HALF_W + 1;

   if (TICK_HALVES < 1 || TICK_HALVES >= MIN_FRAME_HALVES) begin : g_bad_tick
      $error("rxto_half_accum: TICK_HALVES out of range");
   end

   halves_t          acc_q;
   logic [SUM_W-1:0] sum;
   logic             wrap;

   always_comb begin
      sum        = {1'b0, acc_q} + SUM_W'(TICK_HALVES);
      wrap       = sum >= {1'b0, len_halves};
      frame_step = bit_tick && !restart && !hold && wrap;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (restart || expire) begin
         acc_q <= '0;
      end else if (!hold && bit_tick) begin
         acc_q <= wrap ? HALF_W'(sum - {1'b0, len_halves}) : HALF_W'(sum);
      end
   end

   assert_restart_zero_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> acc_q == '0);
   assert_hold_freezes_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !restart) |=> acc_q == $past(acc_q));
   assert_acc_bounded_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      acc_q < HALF_W'(MAX_FRAME_HALVES));
endmodule

// File: rtl/rxto_frame_tally.sv
module rxto_frame_tally #(
   parameter int unsigned CNT_W        = 8,
   parameter bit          ZERO_IS_FULL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_step,
   input  logic             restart,
   input  logic [CNT_W-1:0] frame_limit,
   output logic             expire
);
   localparam int unsigned FR_W = CNT_W + 1;

   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
      $error("rxto_frame_tally: CNT_W out of range");
   end

   logic [FR_W-1:0] limit;
   logic [FR_W-1:0] frames_q;

   if (ZERO_IS_FULL) begin : g_zero_full
      always_comb limit = (frame_limit == '0) ? FR_W'(1) << CNT_W
                                              : FR_W'(frame_limit);
   end else begin : g_zero_one
      always_comb limit = (frame_limit == '0) ? FR_W'(1) : FR_W'(frame_limit);
   end

   always_comb expire = frame_step && ((frames_q + FR_W'(1)) == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frames_q <= '0;
      end else if (restart || expire) begin
         frames_q <= '0;
      end else if (frame_step) begin
         frames_q <= frames_q + FR_W'(1);
      end
   end

   assert_restart_frames_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> frames_q == '0);
   assert_frame_advance_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (frame_step && !restart && !expire) |=> frames_q == $past(frames_q) + FR_W'(1));
endmodule

// File: rtl/rxto_flag.sv
module rxto_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic clr,
   output logic flag_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (expire) flag_q <= 1'b1;
      else if (clr)    flag_q <= 1'b0;
   end

   assert_flag_sticky_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr) |=> flag_q);
   assert_flag_clears_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !expire) |=> !flag_q);
   assert_set_wins_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> flag_q);
endmodule

// File: rtl/uart_rx_idle_timer.sv
module uart_rx_idle_timer
   import rxto_pkg::*;
#(
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned TICK_HALVES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_nonempty,
   input  logic             char_rx,
   input  logic [1:0]       size_code,
   input  logic             parity_en,
   input  logic             long_stop,
   input  logic             bit_tick,
   input  logic [CNT_W-1:0] frame_limit,
   input  logic             flag_clr,
   output logic             timeout_flag
);
   char_fmt_t fmt;
   halves_t   len_halves;
   logic      restart;
   logic      frame_step;
   logic      expire;

   always_comb begin
      fmt     = '{size_code: size_code, parity_on: parity_en, long_stop: long_stop};
      restart = !fifo_nonempty || char_rx;
   end

   rxto_frame_len #(.MIN_DATA_BITS(5), .HALF_STOP_ON_MIN(1'b1)) u_len (
      .fmt        (fmt),
      .len_halves (len_halves)
   );

   rxto_half_accum #(.TICK_HALVES(TICK_HALVES)) u_accum (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_tick   (bit_tick),
      .restart    (restart),
      .hold       (timeout_flag),
      .expire     (expire),
      .len_halves (len_halves),
      .frame_step (frame_step)
   );

   rxto_frame_tally #(.CNT_W(CNT_W), .ZERO_IS_FULL(1'b1)) u_tally (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_step  (frame_step),
      .restart     (restart),
      .frame_limit (frame_limit),
      .expire      (expire)
   );

   rxto_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .expire (expire),
      .clr    (flag_clr),
      .flag_q (timeout_flag)
   );

   assert_rise_needs_data_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout_flag) |-> $past(fifo_nonempty && !char_rx));
   assert_len_legal_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      len_halves >= HALF_W'(MIN_FRAME_HALVES) && len_halves <= HALF_W'(MAX_FRAME_HALVES));
endmodule

// File: tb/uart_rx_idle_timer_bench.sv
module uart_rx_idle_timer_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fifo_nonempty = 1'b0;
   logic       char_rx = 1'b0;
   logic [1:0] size_code = 2'd0;
   logic       parity_en = 1'b0;
   logic       long_stop = 1'b0;
   logic       bit_tick = 1'b0;
   logic [7:0] frame_limit = 8'd1;
   logic       flag_clr = 1'b0;
   logic       timeout_flag;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_rx_idle_timer u_uart_rx_idle_timer (
      .clk(clk), .rst_n(rst_n), .fifo_nonempty(fifo_nonempty), .char_rx(char_rx),
      .size_code(size_code), .parity_en(parity_en), .long_stop(long_stop),
      .bit_tick(bit_tick), .frame_limit(frame_limit), .flag_clr(flag_clr),
      .timeout_flag(timeout_flag)
   );

   function automatic int frame_halves(int code, int par, int ls);
      int stop;
      stop = (ls == 0) ? 2 : ((code == 0) ? 3 : 4);
      return 2 * (1 + code + 5 + par) + stop;
   endfunction

   function automatic int frames_of(int lim);
      return (lim == 0) ? 256 : lim;
   endfunction

   function automatic int ticks_needed(int code, int par, int ls, int lim);
      return (frames_of(lim) * frame_halves(code, par, ls) + 1) / 2;
   endfunction

   task automatic chk(string req, logic act, logic exp);
      @(negedge clk);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s timeout_flag actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic tick_with(logic with_char, logic with_clr);
      repeat ($urandom_range(0, 2)) step();
      bit_tick = 1'b1; char_rx = with_char; flag_clr = with_clr;
      step();
      bit_tick = 1'b0; char_rx = 1'b0; flag_clr = 1'b0;
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) tick_with(1'b0, 1'b0);
   endtask

   task automatic set_fmt(int code, int par, int ls, int lim);
      size_code = 2'(code); parity_en = 1'(par); long_stop = 1'(ls);
      frame_limit = 8'(lim);
   endtask

   task automatic prep();
      fifo_nonempty = 1'b1;
      flag_clr = 1'b1; step(); flag_clr = 1'b0;
      char_rx = 1'b1;  step(); char_rx = 1'b0;
   endtask

   task automatic full_interval(string req, int k);
      ticks(k - 1);
      chk(req, timeout_flag, 1'b0);
      ticks(1);
      chk(req, timeout_flag, 1'b1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog timeout_flag actual=x expected=done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      int k;
      void'($urandom(32'd20240611));
      repeat (3) step();
      chk("R8 reset", timeout_flag, 1'b0);
      set_fmt(3, 0, 0, 3);
      fifo_nonempty = 1'b1;
      rst_n = 1'b1;
      step();
      // R8: data present right after reset needs a full interval (L=20, N=3)
      full_interval("R8 fresh", ticks_needed(3, 0, 0, 3));

      // R5/R3: every size/parity/stop combination
      for (int c = 0; c < 4; c++)
         for (int p = 0; p < 2; p++)
            for (int s = 0; s < 2; s++) begin
               int lim;
               lim = $urandom_range(1, 6);
               set_fmt(c, p, s, lim);
               prep();
               full_interval("R5 R3 frame length", ticks_needed(c, p, s, lim));
            end

      // R4: zero selects 256 frames; 255 selects 255
      set_fmt(0, 0, 0, 0);
      prep();
      full_interval("R4 zero=256", ticks_needed(0, 0, 0, 0));
      set_fmt(0, 0, 0, 255);
      prep();
      full_interval("R4 255", ticks_needed(0, 0, 0, 255));
      set_fmt(0, 1, 1, 0);
      prep();
      full_interval("R4 zero=256 odd len", ticks_needed(0, 1, 1, 0));

      // R2: restart by new character partway through
      set_fmt(1, 1, 1, 4);
      k = ticks_needed(1, 1, 1, 4);
      prep();
      ticks(k - 3);
      char_rx = 1'b1; step(); char_rx = 1'b0;
      full_interval("R2 restart", k);

      // R2: character in the same cycle as the expiring tick
      set_fmt(0, 0, 1, 5);
      k = ticks_needed(0, 0, 1, 5);
      prep();
      ticks(k - 1);
      tick_with(1'b1, 1'b0);
      chk("R2 char beats expiry", timeout_flag, 1'b0);
      full_interval("R2 after collision", k);

      // R1: empty FIFO resets and freezes the count
      set_fmt(2, 0, 0, 2);
      k = ticks_needed(2, 0, 0, 2);
      prep();
      ticks(5);
      fifo_nonempty = 1'b0;
      ticks(3 * k);
      chk("R1 empty no timeout", timeout_flag, 1'b0);
      fifo_nonempty = 1'b1;
      full_interval("R1 refill", k);

      // R6: sticky, no counting while set, full interval after clear
      ticks(2 * k);
      chk("R6 sticky", timeout_flag, 1'b1);
      flag_clr = 1'b1; step(); flag_clr = 1'b0;
      chk("R6 clear", timeout_flag, 1'b0);
      full_interval("R6 rearm", k);

      // R7: clear coincides with the expiring tick
      set_fmt(3, 1, 1, 1);
      k = ticks_needed(3, 1, 1, 1);
      prep();
      ticks(k - 1);
      chk("R7 before", timeout_flag, 1'b0);
      tick_with(1'b0, 1'b1);
      chk("R7 set wins", timeout_flag, 1'b1);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule